// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles conditional branches and jumps while the instruction is still in the decode stage of a five-stage in-order pipeline. It compares the two source operands of a branch and reports the outcome in the same cycle. Each operand comes from the register file, or from the result held in the execute/memory or memory/writeback pipeline register when that result is newer. The branch target is computed for every instruction, alongside the register read, and is used only when a branch is taken. The jump target is assembled from the upper bits of the incremented PC and the jump index.

The block drives the fetch unit directly. It gives a next-PC select code and the chosen address. It raises a flush that turns the fetched instruction into a no-op when a branch is taken or a jump is decoded. It raises a stall when an operand the branch needs cannot be bypassed yet. The stall holds the PC and the fetch/decode register and puts a bubble into the decode/execute register. All outputs are combinational functions of the current inputs.

Top module: `id_branch_resolver`

## Requirements
- R1: When the decode instruction is a branch, the execute/memory stage writes a register, its destination is nonzero and equals the branch's first source, the first comparator input is the execute/memory result instead of the register file value.
- R2: The rule of R1 applies in the same way to the second comparator input, matched against the branch's second source.
- R3: A writing memory/writeback stage whose nonzero destination matches a source forwards its result to that comparator input, unless the execute/memory stage also matches that source; in that case the execute/memory result wins.
- R4: Register 0 is never bypassed and never causes a stall: a producer whose destination is 0 has no effect on the comparison or on the stall output.
- R5: A load in the execute/memory stage whose nonzero destination matches either branch source raises `stall`. A load there with any other destination does not.
- R6: A register-writing instruction in the execute stage whose nonzero destination matches either branch source raises `stall`. Jumps never stall.
- R7: A taken branch sets `pc_sel` to 2'b01 and `next_pc` to PC+4 plus the sign-extended 16-bit offset shifted left by two, and it raises `flush`.
- R8: A jump sets `pc_sel` to 2'b10 and `next_pc` to {PC+4[XLEN-1:28], jump index, 2'b00}, and it raises `flush`.
- R9: With no jump and no taken branch, `pc_sel` is 2'b00, `next_pc` equals PC+4 and `flush` is low.
- R10: While `stall` is high, `flush` is low and `pc_sel` is 2'b00, even if the operands would make the branch taken.
- R11: `br_ne` low makes the branch taken when its operands are equal; `br_ne` high makes it taken when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_is_jump | input | 1 | Decode instruction is an unconditional jump |
| id_br_ne | input | 1 | Branch condition: 0 taken on equal, 1 taken on not equal |
| id_rs | input | REG_AW | First source register index |
| id_rt | input | REG_AW | Second source register index |
| id_pc_plus4 | input | XLEN | Address of the decode instruction plus 4 |
| id_offset | input | 16 | Branch word offset |
| id_jidx | input | 26 | Jump word index |
| rf_rs_data | input | XLEN | Register file value for the first source |
| rf_rt_data | input | XLEN | Register file value for the second source |
| ex_reg_write | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | REG_AW | Execute-stage destination |
| exm_reg_write | input | 1 | Execute/memory instruction writes a register |
| exm_mem_read | input | 1 | Execute/memory instruction is a load |
| exm_rd | input | REG_AW | Execute/memory destination |
| exm_result | input | XLEN | Execute/memory ALU result |
| mwb_reg_write | input | 1 | Memory/writeback instruction writes a register |
| mwb_rd | input | REG_AW | Memory/writeback destination |
| mwb_result | input | XLEN | Memory/writeback write-back value |
| pc_sel | output | 2 | Next-PC select: 00 sequential, 01 branch, 10 jump |
| next_pc | output | XLEN | Selected next fetch address |
| flush | output | 1 | Turn the fetch/decode instruction into a no-op |
| stall | output | 1 | Hold PC and fetch/decode, bubble decode/execute |

## Verification
The bench builds the block with its default parameters: 32-bit data and addresses and 5-bit register indices. With 32-bit addresses, the jump page bits above bit 27 can be set to nonzero values, so the PC+4 concatenation is visible. With 5-bit indices, the bench can pair register 0 with producers that would otherwise match. Each bypass source is made visible through the branch outcome: the register file values are chosen so that only the correct forwarded value makes the comparison come out as expected.

// File: rtl/idbr_pkg.sv
package idbr_pkg;
  typedef enum logic [1:0] {
    PCSEL_SEQ = 2'b00,
    PCSEL_BR  = 2'b01,
    PCSEL_JMP = 2'b10
  } pcsel_e;

  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_EXM = 2'b01,
    BYP_MWB = 2'b10
  } byp_src_e;
endpackage

// File: rtl/idbr_operand_bypass.sv
module idbr_operand_bypass
  import idbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [XLEN-1:0]   rf_data,
  input  logic              exm_wr,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic [XLEN-1:0]   exm_res,
  input  logic              mwb_wr,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic [XLEN-1:0]   mwb_res,
  output logic [XLEN-1:0]   opnd,
  output byp_src_e          src_sel
);
  function automatic logic producer_hits(input logic wr, input logic [REG_AW-1:0] rd,
                                         input logic [REG_AW-1:0] s);
    return wr && (rd != '0) && (rd == s);
  endfunction

  logic exm_hit, mwb_hit;
  assign exm_hit = producer_hits(exm_wr, exm_rd, src);
  assign mwb_hit = producer_hits(mwb_wr, mwb_rd, src);

  // Newer producer first
  always_comb begin
    if (exm_hit)      src_sel = BYP_EXM;
    else if (mwb_hit) src_sel = BYP_MWB;
    else              src_sel = BYP_RF;
  end

  always_comb begin
    unique case (src_sel)
      BYP_EXM: opnd = exm_res;
      BYP_MWB: opnd = mwb_res;
      default: opnd = rf_data;
    endcase
  end

  // R4: register zero always reads from the register file
  always_comb begin
    p_zero_no_bypass_r4: assert ((src != '0) || (opnd == rf_data))
      else $error("register zero bypassed");
  end
endmodule

// File: rtl/idbr_hazard_detect.sv
module idbr_hazard_detect #(
  parameter int REG_AW = 5
) (
  input  logic              is_branch,
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] rt,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              exm_ld,
  input  logic [REG_AW-1:0] exm_rd,
  output logic              ex_dep,
  output logic              ld_dep,
  output logic              stall
);
  function automatic logic reads_reg(input logic [REG_AW-1:0] rd,
                                     input logic [REG_AW-1:0] a,
                                     input logic [REG_AW-1:0] b);
    return (rd != '0) && ((rd == a) || (rd == b));
  endfunction

  // Result one ahead is still in the ALU; load two ahead is still in memory
  assign ex_dep = is_branch && ex_wr  && reads_reg(ex_rd,  rs, rt);
  assign ld_dep = is_branch && exm_ld && reads_reg(exm_rd, rs, rt);
  assign stall  = ex_dep || ld_dep;

  always_comb begin
    p_zero_no_stall_r4: assert (!((rs == '0) && (rt == '0)) || !stall)
      else $error("stall on register zero");
    p_jump_no_stall_r6: assert (is_branch || !stall)
      else $error("stall without a branch");
  end
endmodule

// File: rtl/idbr_pc_select.sv
module idbr_pc_select
  import idbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic              is_branch,
  input  logic              is_jump,
  input  logic              br_ne,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  logic              stall,
  input  logic [XLEN-1:0]   pc4,
  input  logic [OFF_W-1:0]  offset,
  input  logic [JIDX_W-1:0] jidx,
  output pcsel_e            pc_sel,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              flush
);
  localparam int EXT_W = XLEN - OFF_W - 2;

  function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] p,
                                                    input logic [OFF_W-1:0] off);
    return p + {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] p,
                                                  input logic [JIDX_W-1:0] j);
    return {p[XLEN-1:JIDX_W+2], j, 2'b00};
  endfunction

  logic [XLEN-1:0] br_tgt, jmp_tgt;
  logic            ops_equal;

  // Target add runs alongside the register read for every instruction
  assign br_tgt    = branch_target(pc4, offset);
  assign jmp_tgt   = jump_target(pc4, jidx);
  assign ops_equal = (opa == opb);
  assign taken     = is_branch && (ops_equal != br_ne);

  always_comb begin
    if (stall)        pc_sel = PCSEL_SEQ;
    else if (is_jump) pc_sel = PCSEL_JMP;
    else if (taken)   pc_sel = PCSEL_BR;
    else              pc_sel = PCSEL_SEQ;
  end

  always_comb begin
    unique case (pc_sel)
      PCSEL_BR:  next_pc = br_tgt;
      PCSEL_JMP: next_pc = jmp_tgt;
      default:   next_pc = pc4;
    endcase
  end

  assign flush = (pc_sel != PCSEL_SEQ);

  always_comb begin
    p_stall_blocks_flush_r10: assert (!stall || !flush)
      else $error("flush during stall");
    p_taken_redirects_r7: assert (stall || !(taken && !is_jump) || (pc_sel == PCSEL_BR))
      else $error("taken branch not redirected");
  end
endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import idbr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              id_is_branch,
  input  logic              id_is_jump,
  input  logic              id_br_ne,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [XLEN-1:0]   id_pc_plus4,
  input  logic [15:0]       id_offset,
  input  logic [25:0]       id_jidx,
  input  logic [XLEN-1:0]   rf_rs_data,
  input  logic [XLEN-1:0]   rf_rt_data,
  input  logic              ex_reg_write,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              exm_reg_write,
  input  logic              exm_mem_read,
  input  logic [REG_AW-1:0] exm_rd,
  input  logic [XLEN-1:0]   exm_result,
  input  logic              mwb_reg_write,
  input  logic [REG_AW-1:0] mwb_rd,
  input  logic [XLEN-1:0]   mwb_result,
  output logic [1:0]        pc_sel,
  output logic [XLEN-1:0]   next_pc,
  output logic              flush,
  output logic              stall
);
  localparam int NSRC = 2;

  logic [REG_AW-1:0] src_idx [NSRC];
  logic [XLEN-1:0]   src_rf  [NSRC];
  logic [XLEN-1:0]   src_op  [NSRC];
  byp_src_e          src_by  [NSRC];

  assign src_idx[0] = id_rs;
  assign src_idx[1] = id_rt;
  assign src_rf[0]  = rf_rs_data;
  assign src_rf[1]  = rf_rt_data;

  for (genvar i = 0; i < NSRC; i++) begin : g_byp
    idbr_operand_bypass #(.XLEN(XLEN), .REG_AW(REG_AW)) u_byp (
      .src     (src_idx[i]),
      .rf_data (src_rf[i]),
      .exm_wr  (exm_reg_write),
      .exm_rd  (exm_rd),
      .exm_res (exm_result),
      .mwb_wr  (mwb_reg_write),
      .mwb_rd  (mwb_rd),
      .mwb_res (mwb_result),
      .opnd    (src_op[i]),
      .src_sel (src_by[i])
    );
  end

  logic ex_dep, ld_dep, stall_w;

  idbr_hazard_detect #(.REG_AW(REG_AW)) u_haz (
    .is_branch (id_is_branch),
    .rs        (id_rs),
    .rt        (id_rt),
    .ex_wr     (ex_reg_write),
    .ex_rd     (ex_rd),
    .exm_ld    (exm_mem_read),
    .exm_rd    (exm_rd),
    .ex_dep    (ex_dep),
    .ld_dep    (ld_dep),
    .stall     (stall_w)
  );

  pcsel_e sel_w;
  logic   taken_w, flush_w;

  idbr_pc_select #(.XLEN(XLEN), .OFF_W(16), .JIDX_W(26)) u_pcs (
    .is_branch (id_is_branch),
    .is_jump   (id_is_jump),
    .br_ne     (id_br_ne),
    .opa       (src_op[0]),
    .opb       (src_op[1]),
    .stall     (stall_w),
    .pc4       (id_pc_plus4),
    .offset    (id_offset),
    .jidx      (id_jidx),
    .pc_sel    (sel_w),
    .next_pc   (next_pc),
    .taken     (taken_w),
    .flush     (flush_w)
  );

  assign pc_sel = sel_w;
  assign flush  = flush_w;
  assign stall  = stall_w;

  always_comb begin
    p_sel_onehot_r9: assert ($onehot0(pc_sel))
      else $error("illegal pc_sel");
    p_stall_holds_seq_r10: assert (!stall || ((pc_sel == 2'b00) && (next_pc == id_pc_plus4)))
      else $error("stall with redirect");
    p_jump_page_r8: assert ((pc_sel != 2'b10) ||
                            ((next_pc[XLEN-1:28] == id_pc_plus4[XLEN-1:28]) && (next_pc[1:0] == 2'b00)))
      else $error("jump left its page");
    p_ld_dep_stalls_r5: assert (!ld_dep || stall)
      else $error("load dependence without stall");
    p_ex_dep_stalls_r6: assert (!ex_dep || stall)
      else $error("execute dependence without stall");
    p_exm_wins_r3: assert (!((src_by[0] == BYP_MWB) && exm_reg_write && (exm_rd == id_rs) && (id_rs != '0)))
      else $error("older result chosen over newer");
  end
endmodule

// File: tb/id_branch_resolver_tb.sv
module id_branch_resolver_tb;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              id_is_branch, id_is_jump, id_br_ne;
  logic [REG_AW-1:0] id_rs, id_rt, ex_rd, exm_rd, mwb_rd;
  logic [XLEN-1:0]   id_pc_plus4, rf_rs_data, rf_rt_data, exm_result, mwb_result;
  logic [15:0]       id_offset;
  logic [25:0]       id_jidx;
  logic              ex_reg_write, exm_reg_write, exm_mem_read, mwb_reg_write;
  logic [1:0]        pc_sel;
  logic [XLEN-1:0]   next_pc;
  logic              flush, stall;

  id_branch_resolver #(.XLEN(XLEN), .REG_AW(REG_AW)) u_dut (
    .id_is_branch, .id_is_jump, .id_br_ne, .id_rs, .id_rt, .id_pc_plus4,
    .id_offset, .id_jidx, .rf_rs_data, .rf_rt_data, .ex_reg_write, .ex_rd,
    .exm_reg_write, .exm_mem_read, .exm_rd, .exm_result, .mwb_reg_write,
    .mwb_rd, .mwb_result, .pc_sel, .next_pc, .flush, .stall
  );

  typedef struct {
    logic [1:0]      sel;
    logic [XLEN-1:0] pc;
    logic            fl;
    logic            st;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   driving_done = 0;

  function automatic logic [XLEN-1:0] br_addr(logic [XLEN-1:0] p, logic [15:0] off);
    int signed o;
    o = int'($signed(off));
    return p + XLEN'(o * 4);
  endfunction

  task automatic idle();
    id_is_branch = 0; id_is_jump = 0; id_br_ne = 0;
    id_rs = 0; id_rt = 0; id_pc_plus4 = 32'h0000_1004;
    id_offset = 16'h0010; id_jidx = 26'h0;
    rf_rs_data = 0; rf_rt_data = 0;
    ex_reg_write = 0; ex_rd = 0;
    exm_reg_write = 0; exm_mem_read = 0; exm_rd = 0; exm_result = 0;
    mwb_reg_write = 0; mwb_rd = 0; mwb_result = 0;
  endtask

  task automatic push(logic [1:0] s, logic [XLEN-1:0] p, logic f, logic st, string t);
    exp_t e;
    e.sel = s; e.pc = p; e.fl = f; e.st = st; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic check(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // Monitor: compares settled outputs away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "pc_sel", XLEN'(pc_sel), XLEN'(e.sel));
        check(e.tag, "next_pc", next_pc, e.pc);
        check(e.tag, "flush", XLEN'(flush), XLEN'(e.fl));
        check(e.tag, "stall", XLEN'(stall), XLEN'(e.st));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    idle();
    // Idle state: sequential fetch (R9)
    step(); push(2'b00, 32'h0000_1004, 0, 0, "R9 idle");

    // beq equal, positive offset (R7)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 5; rf_rt_data = 5;
    push(2'b01, br_addr(32'h0000_1004, 16'h0010), 1, 0, "R7 fwd");
    // beq equal, negative offset (R7)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 9; rf_rt_data = 9;
    id_offset = 16'hFFFE;
    push(2'b01, 32'h0000_0FFC, 1, 0, "R7 back");
    // beq differ: not taken (R9, R11)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    push(2'b00, 32'h0000_1004, 0, 0, "R9 beq nt");
    // bne differ: taken (R11)
    step(); idle(); id_is_branch = 1; id_br_ne = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    push(2'b01, 32'h0000_1044, 1, 0, "R11 bne t");
    // bne equal: not taken (R11)
    step(); idle(); id_is_branch = 1; id_br_ne = 1; id_rs = 3; id_rt = 4; rf_rs_data = 7; rf_rt_data = 7;
    push(2'b00, 32'h0000_1004, 0, 0, "R11 bne nt");

    // EX/MEM to first input (R1)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    exm_reg_write = 1; exm_rd = 3; exm_result = 2;
    push(2'b01, 32'h0000_1044, 1, 0, "R1 exm rs");
    // EX/MEM to second input (R2)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    exm_reg_write = 1; exm_rd = 4; exm_result = 1;
    push(2'b01, 32'h0000_1044, 1, 0, "R2 exm rt");
    // MEM/WB to second input (R3)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    mwb_reg_write = 1; mwb_rd = 4; mwb_result = 1;
    push(2'b01, 32'h0000_1044, 1, 0, "R3 mwb rt");
    // Both match rt: EX/MEM wins, operands differ, beq not taken (R3)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 1; rf_rt_data = 2;
    exm_reg_write = 1; exm_rd = 4; exm_result = 7; mwb_reg_write = 1; mwb_rd = 4; mwb_result = 1;
    push(2'b00, 32'h0000_1004, 0, 0, "R3 precedence");

    // Producers to r0 are ignored (R4)
    step(); idle(); id_is_branch = 1; id_rs = 0; id_rt = 5; rf_rs_data = 0; rf_rt_data = 0;
    exm_reg_write = 1; exm_rd = 0; exm_result = 9; mwb_reg_write = 1; mwb_rd = 0; mwb_result = 8;
    ex_reg_write = 1; ex_rd = 0;
    push(2'b01, 32'h0000_1044, 1, 0, "R4 zero");

    // Load two ahead matching rs: stall (R5, R10)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 6; rf_rt_data = 6;
    exm_reg_write = 1; exm_mem_read = 1; exm_rd = 3;
    push(2'b00, 32'h0000_1004, 0, 1, "R5 load stall");
    // Load two ahead to another register: no stall (R5)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 6; rf_rt_data = 6;
    exm_reg_write = 1; exm_mem_read = 1; exm_rd = 9;
    push(2'b01, 32'h0000_1044, 1, 0, "R5 load free");
    // ALU one ahead writes rt: stall, flush suppressed (R6, R10)
    step(); idle(); id_is_branch = 1; id_rs = 3; id_rt = 4; rf_rs_data = 6; rf_rt_data = 6;
    ex_reg_write = 1; ex_rd = 4;
    push(2'b00, 32'h0000_1004, 0, 1, "R10 ex stall");

    // Jump with page bits (R8); execute match must not stall (R6)
    step(); idle(); id_is_jump = 1; id_pc_plus4 = 32'hA000_1004; id_jidx = 26'h0123456;
    ex_reg_write = 1; ex_rd = 3; id_rs = 3;
    push(2'b10, 32'hA048_D158, 1, 0, "R8 jump");

    step(); idle();
    push(2'b00, 32'h0000_1004, 0, 0, "R9 after");
    driving_done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!(driving_done && exp_q.size() == 0) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule